// File: doc/BRIEF.md
# Guarded Configuration Register Controller

This block owns a single configuration byte that sits at a reserved address of a byte-oriented serial memory bus. A bus front end, not part of this block, turns line activity into one-cycle events: start, high address byte, low address byte, write data byte, read request and stop. The block answers each address and data byte with an acknowledge decision. It returns the register byte on a read. It applies the unlock sequence that guards the stored fields. Accesses to any other address are flagged for the memory path and leave the register alone.

The stored part holds a write-protect enable, a two-bit watchdog period select and a three-bit block-protect select. These bits are non-volatile: the reset input models a power cycle and clears only the volatile unlock latches and the bus state. To change the stored fields, the host first sets the first latch and then the second, and only a third write with the proper latch pattern lands in the stored fields. That write starts a timed store, and the block refuses new addresses until the store is finished.

Top module: `cfgguard_top`

## Requirements
- R1: Only the 16-bit address FFFFh, sent high byte first, selects the register. Any other address raises `mem_sel` until the next stop or start, gets no acknowledge on its data bytes and leaves every stored field unchanged.
- R2: A read request after the register address returns one byte, with bit 7 = write-protect enable, bits 6:5 = watchdog select, bits 4:3 = block-protect bits 1:0, bit 2 = second latch, bit 1 = first latch and bit 0 = block-protect bit 2. The block then returns to idle, so a second read request without a new start returns nothing.
- R3: In one register write, the first data byte is acknowledged. Every later data byte gets `ack_valid`=1 with `ack`=0 and has no effect.
- R4: Nothing written takes effect until a stop follows the data byte. A new start in its place discards the byte.
- R5: Writing 02h sets the first latch and clears the second. Writing 06h sets the second latch only if the first is already set.
- R6: When both latches are set, a written byte whose bits 2:1 equal 01 copies bits 7:3 and bit 0 into the stored fields. It then clears the second latch and leaves the first set.
- R7: Writing 00h clears both latches. Any other write that is out of sequence leaves the stored fields unchanged.
- R8: A stored-field update raises `busy` for exactly STORE_CYC cycles, starting the cycle after the stop. During that time a high address byte gets `ack_valid`=1 with `ack`=0.
- R9: Reset clears both latches, `busy` and the bus state, and keeps the stored fields.
- R10: The register can be read while write protect is enabled.
- R11: `wp_en`, `wd_sel` and `bp_sel` always show the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, models power-on |
| ev_valid | input | 1 | A bus event is present this cycle |
| ev_kind | input | 3 | Event code: 0 start, 1 address high, 2 address low, 3 write data, 4 read, 5 stop |
| ev_byte | input | 8 | Address or data byte of the event |
| ack_valid | output | 1 | An acknowledge decision is presented this cycle |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_valid | output | 1 | Read byte is presented this cycle |
| rd_data | output | 8 | Register byte returned by a read |
| mem_sel | output | 1 | Current transaction targets the memory path |
| busy | output | 1 | Non-volatile store in progress |
| wp_en | output | 1 | Stored write-protect enable |
| wd_sel | output | 2 | Stored watchdog period select |
| bp_sel | output | 3 | Stored block-protect select |

## Verification
The bench targets the unlock ladder. It sends the final value without latches, 06h without the first latch, and a stop-less abort of an armed write. In each case a design that skipped a step would alter the stored fields while the latches read back clear. A second data byte in one write must be refused; a design that took it would acknowledge it or store the later value. During the timed store, an address sent straight after the stop must be refused, and `busy` must last exactly the set number of cycles. A design that acknowledged early would start transactions in the middle of the store. Reset must keep the stored fields while dropping the latches, and a repeated read must return nothing.

// File: rtl/cfgguard_pkg.sv
package cfgguard_pkg;
  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_ADDR_HI = 3'd1,
    EV_ADDR_LO = 3'd2,
    EV_WDATA   = 3'd3,
    EV_READ    = 3'd4,
    EV_STOP    = 3'd5
  } ev_kind_e;

  typedef struct packed {
    logic       wpen;
    logic [1:0] wd;
    logic [2:0] bp;
  } nv_fields_t;
endpackage

// File: rtl/cfgguard_seq.sv
module cfgguard_seq
  import cfgguard_pkg::*;
#(
  parameter logic [15:0] REG_ADDR = 16'hFFFF,
  parameter int          BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  ev_kind_e          ev_kind,
  input  logic [BYTE_W-1:0] ev_byte,
  input  logic              busy,
  input  logic [BYTE_W-1:0] reg_view,
  output logic              ack_valid,
  output logic              ack,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              mem_sel,
  output logic              commit,
  output logic [BYTE_W-1:0] commit_byte
);
  typedef enum logic [2:0] {SQ_IDLE, SQ_AHI, SQ_ALO, SQ_REG, SQ_REGW, SQ_MEM} sq_e;

  sq_e              st;
  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] wbyte_q;
  logic              match;

  assign match       = ({hi_q, ev_byte} == REG_ADDR);
  assign commit      = ev_valid && (ev_kind == EV_STOP) && (st == SQ_REGW);
  assign commit_byte = wbyte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      mem_sel   <= 1'b0;
      hi_q      <= '0;
      wbyte_q   <= '0;
    end else begin
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      rd_valid  <= 1'b0;
      if (ev_valid) begin
        case (ev_kind)
          EV_START: begin
            st      <= SQ_AHI;
            mem_sel <= 1'b0;
          end
          EV_ADDR_HI: if (st == SQ_AHI) begin
            ack_valid <= 1'b1;
            ack       <= !busy;
            hi_q      <= ev_byte;
            st        <= busy ? SQ_IDLE : SQ_ALO;
          end
          EV_ADDR_LO: if (st == SQ_ALO) begin
            ack_valid <= 1'b1;
            ack       <= !busy;
            if (busy)       st <= SQ_IDLE;
            else if (match) st <= SQ_REG;
            else begin
              st      <= SQ_MEM;
              mem_sel <= 1'b1;
            end
          end
          EV_WDATA: begin
            if (st == SQ_REG) begin
              ack_valid <= 1'b1;
              ack       <= 1'b1;
              wbyte_q   <= ev_byte;
              st        <= SQ_REGW;
            end else if (st == SQ_REGW) begin
              ack_valid <= 1'b1;
              ack       <= 1'b0;
            end
          end
          EV_READ: if (st == SQ_REG) begin
            rd_valid <= 1'b1;
            rd_data  <= reg_view;
            st       <= SQ_IDLE;
          end
          EV_STOP: begin
            st      <= SQ_IDLE;
            mem_sel <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  a_r3_extra_byte_nack: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == EV_WDATA && st == SQ_REGW) |=> (ack_valid && !ack));
  a_r8_busy_addr_nack: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == EV_ADDR_HI && st == SQ_AHI && busy) |=> (ack_valid && !ack));
  a_r2_read_then_idle: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (st == SQ_IDLE));
  a_r1_mem_never_commits: assert property (@(posedge clk) disable iff (rst)
    mem_sel |-> !commit);
endmodule

// File: rtl/cfgguard_lock.sv
module cfgguard_lock
  import cfgguard_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [BYTE_W-1:0] commit_byte,
  output logic              wel,
  output logic              rwel,
  output nv_fields_t        fields,
  output logic              nv_write
);
  localparam logic [BYTE_W-1:0] CMD_CLEAR = BYTE_W'(8'h00);
  localparam logic [BYTE_W-1:0] CMD_STEP1 = BYTE_W'(8'h02);
  localparam logic [BYTE_W-1:0] CMD_STEP2 = BYTE_W'(8'h06);

  logic       wel_q, rwel_q;
  nv_fields_t nv_q = '0;
  logic       is_clear, is_step1, is_step2, final_pat;

  assign is_clear  = (commit_byte == CMD_CLEAR);
  assign is_step1  = (commit_byte == CMD_STEP1);
  assign is_step2  = (commit_byte == CMD_STEP2);
  assign final_pat = (commit_byte[2:1] == 2'b01);
  assign nv_write  = commit && !is_clear && wel_q && rwel_q && final_pat;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (commit) begin
      if (is_clear) begin
        wel_q  <= 1'b0;
        rwel_q <= 1'b0;
      end else if (nv_write) begin
        rwel_q <= 1'b0;
      end else if (is_step1) begin
        wel_q  <= 1'b1;
        rwel_q <= 1'b0;
      end else if (is_step2 && wel_q) begin
        rwel_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (nv_write) begin
      nv_q.wpen <= commit_byte[7];
      nv_q.wd   <= commit_byte[6:5];
      nv_q.bp   <= {commit_byte[0], commit_byte[4:3]};
    end
  end

  assign wel    = wel_q;
  assign rwel   = rwel_q;
  assign fields = nv_q;

  a_r7_rwel_needs_wel: assert property (@(posedge clk) disable iff (rst)
    rwel_q |-> wel_q);
  a_r6_locked_fields_hold: assert property (@(posedge clk) disable iff (rst)
    (commit && !(wel_q && rwel_q)) |=> $stable(nv_q));
  a_r7_zero_clears: assert property (@(posedge clk) disable iff (rst)
    (commit && commit_byte == '0) |=> (!wel_q && !rwel_q));
  a_r6_update_drops_rwel: assert property (@(posedge clk) disable iff (rst)
    nv_write |=> (wel_q && !rwel_q));
endmodule

// File: rtl/cfgguard_timer.sv
module cfgguard_timer #(
  parameter int STORE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(STORE_CYC + 1);

  logic [CW-1:0] cnt;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt    <= CW'(STORE_CYC - 1);
    end else if (busy_q) begin
      if (cnt == '0) busy_q <= 1'b0;
      else           cnt    <= cnt - CW'(1);
    end
  end

  assign busy = busy_q;

  a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q);
  a_r8_count_in_range: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt < CW'(STORE_CYC)));
endmodule

// File: rtl/cfgguard_top.sv
module cfgguard_top
  import cfgguard_pkg::*;
#(
  parameter logic [15:0] REG_ADDR  = 16'hFFFF,
  parameter int          STORE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_valid,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  output logic       ack_valid,
  output logic       ack,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       mem_sel,
  output logic       busy,
  output logic       wp_en,
  output logic [1:0] wd_sel,
  output logic [2:0] bp_sel
);
  localparam int BYTE_W = 8;

  logic              wel, rwel, commit, nv_write;
  logic [BYTE_W-1:0] commit_byte, reg_view;
  nv_fields_t        fields;

  assign reg_view = {fields.wpen, fields.wd, fields.bp[1:0], rwel, wel, fields.bp[2]};

  cfgguard_seq #(.REG_ADDR(REG_ADDR), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind_e'(ev_kind)),
    .ev_byte(ev_byte), .busy(busy), .reg_view(reg_view),
    .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_sel(mem_sel), .commit(commit), .commit_byte(commit_byte)
  );

  cfgguard_lock #(.BYTE_W(BYTE_W)) u_lock (
    .clk(clk), .rst(rst), .commit(commit), .commit_byte(commit_byte),
    .wel(wel), .rwel(rwel), .fields(fields), .nv_write(nv_write)
  );

  cfgguard_timer #(.STORE_CYC(STORE_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(nv_write), .busy(busy)
  );

  assign wp_en  = fields.wpen;
  assign wd_sel = fields.wd;
  assign bp_sel = fields.bp;
endmodule

// File: tb/tb_cfgguard_top.sv
module tb_cfgguard_top;
  localparam int STORE_CYC = 16;
  localparam logic [2:0] K_START = 3'd0, K_AH = 3'd1, K_AL = 3'd2,
                         K_WD = 3'd3, K_RD = 3'd4, K_STOP = 3'd5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = '0;
  logic [7:0] ev_byte = '0;
  logic       ack_valid, ack, rd_valid, mem_sel, busy, wp_en;
  logic [7:0] rd_data;
  logic [1:0] wd_sel;
  logic [2:0] bp_sel;

  cfgguard_top #(.STORE_CYC(STORE_CYC)) dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_sel(mem_sel), .busy(busy), .wp_en(wp_en), .wd_sel(wd_sel), .bp_sel(bp_sel)
  );

  always #2 clk = ~clk;

  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  logic m_wel = 0, m_rwel = 0, m_wp = 0;
  logic [1:0] m_wd = 0;
  logic [2:0] m_bp = 0;
  logic r_ackv, r_ack, r_rdv;
  logic [7:0] r_rd;
  bit   g_upd;

  function automatic logic [7:0] view();
    return {m_wp, m_wd, m_bp[1:0], m_rwel, m_wel, m_bp[2]};
  endfunction

  function automatic bit apply(logic [7:0] b);
    if (b == 8'h00) begin m_wel = 0; m_rwel = 0; return 0; end
    if (m_wel && m_rwel && b[2:1] == 2'b01) begin
      m_wp = b[7]; m_wd = b[6:5]; m_bp = {b[0], b[4:3]}; m_rwel = 0; return 1;
    end
    if (b == 8'h02) begin m_wel = 1; m_rwel = 0; return 0; end
    if (b == 8'h06 && m_wel) m_rwel = 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ev(logic [2:0] k, logic [7:0] b);
    ev_valid = 1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 0;
    r_ackv = ack_valid; r_ack = ack; r_rdv = rd_valid; r_rd = rd_data;
  endtask

  task automatic chk_fields(string tag);
    chk({wp_en, wd_sel, bp_sel} == {m_wp, m_wd, m_bp}, tag,
        {wp_en, wd_sel, bp_sel}, {m_wp, m_wd, m_bp});
  endtask

  task automatic wr_reg(logic [7:0] b, int extra, bit do_stop);
    ev(K_START, 0);
    ev(K_AH, 8'hFF); chk(r_ackv && r_ack, "R1 addr hi ack", r_ack, 1);
    ev(K_AL, 8'hFF); chk(r_ackv && r_ack, "R1 addr lo ack", r_ack, 1);
    ev(K_WD, b);     chk(r_ackv && r_ack, "R3 first byte ack", r_ack, 1);
    for (int i = 0; i < extra; i++) begin
      ev(K_WD, 8'($urandom)); chk(r_ackv && !r_ack, "R3 extra byte nack", r_ack, 0);
    end
    g_upd = 0;
    if (do_stop) begin
      ev(K_STOP, 0);
      g_upd = apply(b);
      chk(busy == g_upd, "R8 busy after stop", busy, g_upd);
    end
    chk_fields("R11 fields after write");
  endtask

  task automatic rd_reg(string tag);
    ev(K_START, 0); ev(K_AH, 8'hFF); ev(K_AL, 8'hFF);
    ev(K_RD, 0);
    chk(r_rdv && r_rd == view(), tag, r_rd, view());
    ev(K_RD, 0);
    chk(!r_rdv, "R2 second read empty", r_rdv, 0);
    ev(K_STOP, 0);
  endtask

  task automatic mem_acc();
    logic [7:0] hi, lo;
    hi = 8'($urandom); lo = 8'($urandom);
    if ({hi, lo} == 16'hFFFF) lo = 8'h00;
    ev(K_START, 0); ev(K_AH, hi); ev(K_AL, lo);
    chk(mem_sel, "R1 mem_sel set", mem_sel, 1);
    ev(K_WD, 8'h9B);
    chk(!r_ackv, "R1 mem data not acked", r_ackv, 0);
    ev(K_STOP, 0);
    chk(!mem_sel, "R1 mem_sel cleared", mem_sel, 0);
    chk_fields("R1 fields untouched by memory access");
  endtask

  function automatic int count_busy_init();
    return 0;
  endfunction

  task automatic wait_busy(output int c);
    c = count_busy_init();
    while (busy === 1'b1 && c < 10000) begin c++; @(negedge clk); end
  endtask

  initial begin
    int c;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // Reset state
    chk(!busy && !ack_valid && !rd_valid && !mem_sel, "R9 reset outputs idle", busy, 0);
    chk_fields("R11 fields at reset");
    rd_reg("R2 read after reset");
    // Out of sequence writes
    wr_reg(8'hDB, 0, 1); rd_reg("R7 final value without latches ignored");
    wr_reg(8'h06, 0, 1); rd_reg("R5 06h without first latch ignored");
    wr_reg(8'h02, 0, 1); rd_reg("R5 02h sets first latch");
    wr_reg(8'h06, 0, 1); rd_reg("R5 06h sets second latch");
    // Protected update with an extra byte, busy length
    wr_reg(8'hDB, 1, 1);
    wait_busy(c);
    chk(c == STORE_CYC, "R8 busy length", c, STORE_CYC);
    rd_reg("R6 protected update stored");
    chk(wp_en == 1'b1, "R10 write protect on", wp_en, 1);
    rd_reg("R10 read while write protected");
    // Busy nack on new address
    wr_reg(8'h06, 0, 1);
    wr_reg(8'h03, 0, 1);
    ev(K_START, 0); ev(K_AH, 8'hFF);
    chk(r_ackv && !r_ack, "R8 address nack while busy", r_ack, 0);
    ev(K_STOP, 0);
    wait_busy(c);
    rd_reg("R6 second update stored");
    // Abort without stop
    wr_reg(8'h06, 0, 1);
    wr_reg(8'hFB, 0, 0);
    rd_reg("R4 aborted write has no effect");
    // Explicit clear
    wr_reg(8'h00, 0, 1); rd_reg("R7 00h clears latches");
    // Reset keeps stored fields
    wr_reg(8'h02, 0, 1);
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    m_wel = 0; m_rwel = 0;
    chk_fields("R9 fields survive reset");
    rd_reg("R9 latches cleared by reset");
    // Random mix
    for (int t = 0; t < 300; t++) begin
      int sel;
      logic [7:0] b;
      sel = int'($urandom % 7);
      case (int'($urandom % 5))
        0: b = 8'h00;
        1: b = 8'h02;
        2: b = 8'h06;
        3: b = (8'($urandom) & 8'hF9) | 8'h02;
        default: b = 8'($urandom);
      endcase
      if (sel < 3) begin
        wr_reg(b, int'($urandom % 2), 1);
        if (g_upd) begin
          wait_busy(c);
          chk(c == STORE_CYC, "R8 busy length random", c, STORE_CYC);
        end
      end else if (sel == 3) wr_reg(b, 0, 0);
      else if (sel == 4) mem_acc();
      else rd_reg("R2 random read");
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule